// File: doc/BRIEF.md
# Per-Interface Reset Controller

This block supervises the life of up to `N` lightweight virtual interfaces that share one parent function. Each interface is either running, being torn down, or switched off. A per-interface reset request tears down a single interface. The controller withdraws its enable and raises its abort line so the DMA engine drops that interface's in-flight work. It then waits for the engine to report that nothing is outstanding for the interface. Next it fires a one-cycle clear strobe to the register file, which reloads the interface's architected registers. The reload takes either the defaults or a freshly programmed configuration, such as a new requester ID or a new memory window. Finally the controller re-enables the interface. Every other interface keeps running throughout.

The controller never drives state that persists across instantiations; only the architected registers receive a clear. A parent-function level reset switches off every interface below the advertised count in one cycle. Software later brings each interface back with an enable request, which runs through the same drain-and-reload sequence. Each return to service is announced by a one-cycle done pulse that carries the interface index.

Top module: `iface_reset_ctrl`

## Requirements
- R1: After reset every interface is off: `ifEnable` all 0, `ifAbort` all 1, `ifClear` all 0, `doneValid` 0.
- R2: An enable request (`reqOp`=1) for an off interface, or a reset request for a running one, ends with one `doneValid` pulse one cycle wide, with `doneIdx` equal to the interface. The cycle after its clear strobe, `ifEnable` for that interface is 1.
- R3: A reset request (`reqOp`=0) for a running interface makes its `ifEnable` 0 and `ifAbort` 1 on the next cycle, and leaves `ifEnable` of all other interfaces unchanged.
- R4: While `drained` for an interface under reset is 0, no clear strobe and no done pulse are issued for it.
- R5: Each completed reset issues exactly one `ifClear` strobe, and only on the bit of that interface. `clearNew` is 1 with it when a new configuration was requested (`reqNewCfg`=1) and 0 for a restore to defaults. At most one clear is issued per cycle. When several are ready, the lowest index goes first.
- R6: A reset request for an interface already in reset is merged: no second clear or done pulse. The new-configuration flag of the merged request is ORed into the pending one.
- R7: A reset request for an off interface, and an enable request for an interface not off, have no effect.
- R8: A function level reset (`flrReq`=1) turns off, on the next cycle, every interface with index below `advCount` (`ifEnable` 0, `ifAbort` 1). It cancels their pending resets so no done pulse follows. It ignores any request in the same cycle and leaves higher indices untouched. Interfaces turned off this way return only through an enable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe |
| reqOp | input | 1 | 0 = reset interface, 1 = enable interface |
| reqIdx | input | $clog2(N) | Target interface |
| reqNewCfg | input | 1 | 1 = reload a new configuration, 0 = defaults |
| flrReq | input | 1 | Function level reset strobe |
| advCount | input | $clog2(N+1) | Advertised number of interfaces |
| drained | input | N | Per-interface outstanding-DMA count is zero |
| ifEnable | output | N | Interface may operate |
| ifAbort | output | N | DMA engine must drop the interface's work |
| ifClear | output | N | One-cycle reload strobe to the architected registers |
| clearNew | output | 1 | Reload selects the new configuration |
| doneValid | output | 1 | Interface returned to service |
| doneIdx | output | $clog2(N) | Index of that interface |

## Verification
The hardest situations to reach are the ones where two interfaces wait on the drain at once, and where a function level reset lands on an interface that is stuck mid-reset. The bench controls each interface's `drained` input directly. It holds the line low for the interfaces it wants to park in the abort phase, and stacks or merges requests there. It then releases several lines in the same cycle to force the restore arbiter to order them, or fires the function level reset while one interface is still parked.

// File: rtl/iface_reset_pkg.sv
package iface_reset_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE    = 3'd0,
    ST_ABORTING  = 3'd1,
    ST_DRAINED   = 3'd2,
    ST_RESTORING = 3'd3,
    ST_DISABLED  = 3'd4
  } ifState_e;

  // strobes from the control FSMs to the datapath
  typedef struct packed {
    logic valid;   // one interface is reloaded this cycle
    logic useNew;  // reload takes the new configuration
  } restoreStrobe_t;

endpackage

// File: rtl/iface_reset_pick.sv
module iface_reset_pick #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          anyReq,
  output logic [IW-1:0] pickIdx
);
  // lowest index wins
  always_comb begin
    anyReq  = 1'b0;
    pickIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        anyReq  = 1'b1;
        pickIdx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/iface_reset_fsm.sv
module iface_reset_fsm
  import iface_reset_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   rstHit,
  input  logic [N-1:0]   enHit,
  input  logic [N-1:0]   flrHit,
  input  logic           newSel,
  input  logic [N-1:0]   drained,
  output logic [N-1:0]   ifEnable,
  output logic [N-1:0]   ifAbort,
  output restoreStrobe_t strobe,
  output logic [IW-1:0]  restoreIdx
);
  ifState_e   st [N];
  logic [N-1:0] pendNew;
  logic [N-1:0] restoreReady;
  logic [N-1:0] grant;
  logic         anyRestore;
  logic [IW-1:0] pickIdx;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : gOut
      assign restoreReady[g] = (st[g] == ST_RESTORING) && !flrHit[g];
      assign ifEnable[g]     = (st[g] == ST_ACTIVE);
      assign ifAbort[g]      = (st[g] != ST_ACTIVE);
      assign grant[g]        = anyRestore && (pickIdx == IW'(g));
    end
  endgenerate

  iface_reset_pick #(.N(N)) uPick (
    .req    (restoreReady),
    .anyReq (anyRestore),
    .pickIdx(pickIdx)
  );

  assign strobe.valid  = anyRestore;
  assign strobe.useNew = anyRestore && pendNew[pickIdx];
  assign restoreIdx    = pickIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N; i++) st[i] <= ST_DISABLED;
      pendNew <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flrHit[i]) begin
          st[i]      <= ST_DISABLED;
          pendNew[i] <= 1'b0;
        end else begin
          unique case (st[i])
            ST_ACTIVE: if (rstHit[i]) begin
              st[i]      <= ST_ABORTING;
              pendNew[i] <= newSel;
            end
            ST_ABORTING: begin
              if (rstHit[i]) pendNew[i] <= pendNew[i] | newSel;
              if (drained[i]) st[i] <= ST_DRAINED;
            end
            ST_DRAINED: begin
              if (rstHit[i]) pendNew[i] <= pendNew[i] | newSel;
              st[i] <= ST_RESTORING;
            end
            ST_RESTORING: begin
              if (grant[i]) begin
                st[i]      <= ST_ACTIVE;
                pendNew[i] <= 1'b0;
              end else if (rstHit[i]) begin
                pendNew[i] <= pendNew[i] | newSel;
              end
            end
            ST_DISABLED: if (enHit[i]) begin
              st[i]      <= ST_ABORTING;
              pendNew[i] <= newSel;
            end
            default: st[i] <= ST_DISABLED;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/iface_reset_dp.sv
module iface_reset_dp
  import iface_reset_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic           reqOp,
  input  logic [IW-1:0]  reqIdx,
  input  logic           reqNewCfg,
  input  logic           flrReq,
  input  logic [CW-1:0]  advCount,
  input  restoreStrobe_t strobe,
  input  logic [IW-1:0]  restoreIdx,
  output logic [N-1:0]   rstHit,
  output logic [N-1:0]   enHit,
  output logic [N-1:0]   flrHit,
  output logic           newSel,
  output logic [N-1:0]   ifClear,
  output logic           clearNew,
  output logic           doneValid,
  output logic [IW-1:0]  doneIdx
);
  logic acceptReq;
  assign acceptReq = reqValid && !flrReq;
  assign newSel    = reqNewCfg;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : gDec
      assign rstHit[g]  = acceptReq && !reqOp && (reqIdx == IW'(g));
      assign enHit[g]   = acceptReq &&  reqOp && (reqIdx == IW'(g));
      assign flrHit[g]  = flrReq && (CW'(g) < advCount);
      assign ifClear[g] = strobe.valid && (restoreIdx == IW'(g));
    end
  endgenerate

  assign clearNew = strobe.valid && strobe.useNew;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid <= 1'b0;
      doneIdx   <= '0;
    end else begin
      doneValid <= strobe.valid;
      if (strobe.valid) doneIdx <= restoreIdx;
    end
  end
endmodule

// File: rtl/iface_reset_ctrl.sv
module iface_reset_ctrl
  import iface_reset_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqOp,
  input  logic [IW-1:0] reqIdx,
  input  logic          reqNewCfg,
  input  logic          flrReq,
  input  logic [CW-1:0] advCount,
  input  logic [N-1:0]  drained,
  output logic [N-1:0]  ifEnable,
  output logic [N-1:0]  ifAbort,
  output logic [N-1:0]  ifClear,
  output logic          clearNew,
  output logic          doneValid,
  output logic [IW-1:0] doneIdx
);
  logic [N-1:0]   rstHit, enHit, flrHit;
  logic           newSel;
  restoreStrobe_t strobe;
  logic [IW-1:0]  restoreIdx;

  iface_reset_dp #(.N(N)) uDp (
    .clk, .rstN, .reqValid, .reqOp, .reqIdx, .reqNewCfg, .flrReq, .advCount,
    .strobe, .restoreIdx, .rstHit, .enHit, .flrHit, .newSel,
    .ifClear, .clearNew, .doneValid, .doneIdx
  );

  iface_reset_fsm #(.N(N)) uFsm (
    .clk, .rstN, .rstHit, .enHit, .flrHit, .newSel, .drained,
    .ifEnable, .ifAbort, .strobe, .restoreIdx
  );
endmodule

// File: rtl/iface_reset_chk.sv
module iface_reset_chk #(
  parameter int N  = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          reqValid,
  input logic          reqOp,
  input logic [IW-1:0] reqIdx,
  input logic          flrReq,
  input logic [CW-1:0] advCount,
  input logic [N-1:0]  ifEnable,
  input logic [N-1:0]  ifAbort,
  input logic [N-1:0]  ifClear,
  input logic          doneValid,
  input logic [IW-1:0] doneIdx
);
  logic [N-1:0] clrQ, keepQ, maskQ;
  logic         flrQ, seenQ;
  logic [N-1:0] resetSel, flrMask;

  always_comb begin
    resetSel = '0;
    if (reqValid && !reqOp) resetSel[reqIdx] = 1'b1;
    for (int i = 0; i < N; i++) flrMask[i] = (CW'(i) < advCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clrQ <= '0; keepQ <= '0; maskQ <= '0; flrQ <= 1'b0; seenQ <= 1'b0;
    end else begin
      clrQ  <= ifClear;
      keepQ <= ifEnable & ~resetSel;
      maskQ <= flrReq ? flrMask : '0;
      flrQ  <= flrReq;
      seenQ <= 1'b1;
    end
  end

  a_r5_one_clear: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ifClear));

  a_r2_done_after_clear: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (clrQ[doneIdx] && ifEnable[doneIdx]));

  a_r3_abort_on_reset: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqOp && !flrReq && ifEnable[reqIdx]) |=> ifAbort[$past(reqIdx)]);

  a_r3_others_stay: assert property (@(posedge clk) disable iff (!rstN)
    (seenQ && !flrQ) |-> ((keepQ & ~ifEnable) == '0));

  a_r8_flr_off: assert property (@(posedge clk) disable iff (!rstN)
    flrQ |-> (((maskQ & ifEnable) == '0) && ((maskQ & ~ifAbort) == '0)));

  a_r8_no_done: assert property (@(posedge clk) disable iff (!rstN)
    (flrQ && doneValid) |-> !maskQ[doneIdx]);
endmodule

bind iface_reset_ctrl iface_reset_chk #(.N(N)) uChk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqIdx(reqIdx),
  .flrReq(flrReq), .advCount(advCount), .ifEnable(ifEnable), .ifAbort(ifAbort),
  .ifClear(ifClear), .doneValid(doneValid), .doneIdx(doneIdx)
);

// File: tb/sim_iface_reset_ctrl.sv
module sim_iface_reset_ctrl;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0, reqOp = 1'b0, reqNewCfg = 1'b0, flrReq = 1'b0;
  logic [2:0] reqIdx = '0;
  logic [3:0] advCount = 4'd8;
  logic [N-1:0] drained = '1;
  logic [N-1:0] ifEnable, ifAbort, ifClear;
  logic       clearNew, doneValid;
  logic [2:0] doneIdx;

  always #2.5 clk = ~clk;

  iface_reset_ctrl #(.N(N)) u0 (.*);

  int checks = 0, failures = 0, cycles = 0;
  int clrCnt [N];
  int doneCnt [N];
  logic lastNew [N];
  logic [7:0] archReg [N];
  int doneHist [64];
  int doneN = 0, badDone = 0;

  // observer and register-file model
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rstN) begin
      for (int i = 0; i < N; i++) if (ifClear[i]) begin
        clrCnt[i]++;
        lastNew[i] = clearNew;
        archReg[i] <= clearNew ? (8'hA0 + 8'(i)) : (8'h10 + 8'(i));
      end
      if (doneValid) begin
        doneCnt[doneIdx]++;
        if (doneN < 64) doneHist[doneN] = int'(doneIdx);
        doneN++;
        if (!ifEnable[doneIdx]) badDone++;
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(negedge clk) if (cycles > 50000) begin
    failures++;
    $display("FAIL watchdog all-R actual=%0d cycles expected=finish", cycles);
    summary();
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic req(input logic op, input int idx, input logic nw);
    reqValid = 1'b1; reqOp = op; reqIdx = 3'(idx); reqNewCfg = nw;
    @(negedge clk);
    reqValid = 1'b0; reqNewCfg = 1'b0;
  endtask

  // op, idx, newCfg, drain delay, done expected
  localparam logic [9:0] VEC [6] = '{
    {1'b0, 3'd2, 1'b0, 4'd0, 1'b1},
    {1'b0, 3'd5, 1'b1, 4'd3, 1'b1},
    {1'b1, 3'd3, 1'b0, 4'd0, 1'b0},
    {1'b0, 3'd7, 1'b1, 4'd6, 1'b1},
    {1'b0, 3'd0, 1'b0, 4'd1, 1'b1},
    {1'b1, 3'd6, 1'b1, 4'd0, 1'b0}
  };

  initial begin
    for (int i = 0; i < N; i++) begin
      clrCnt[i] = 0; doneCnt[i] = 0; lastNew[i] = 0; archReg[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ifEnable == '0 && ifAbort == '1 && ifClear == '0 && !doneValid,
          "R1 reset state", {ifEnable, ifAbort}, {8'h00, 8'hFF});
    rstN = 1'b1;
    @(negedge clk);

    // R2 bring every interface up
    for (int i = 0; i < N; i++) begin
      req(1'b1, i, 1'b0);
      repeat (6) @(negedge clk);
      check(doneCnt[i] == 1 && ifEnable[i], "R2 enable done", doneCnt[i], 1);
    end
    check(ifEnable == '1, "R2 all enabled", ifEnable, 8'hFF);

    // table walk
    for (int v = 0; v < 6; v++) begin
      automatic logic op = VEC[v][9];
      automatic int idx = int'(VEC[v][8:6]);
      automatic logic nw = VEC[v][5];
      automatic int dly = int'(VEC[v][4:1]);
      automatic logic ex = VEC[v][0];
      automatic logic [N-1:0] sel = N'(1) << idx;
      automatic logic [N-1:0] enBefore = ifEnable;
      automatic int c0 = clrCnt[idx], d0 = doneCnt[idx], tot0 = 0, tot1 = 0;
      for (int i = 0; i < N; i++) tot0 += clrCnt[i];
      if (dly > 0) drained[idx] = 1'b0;
      req(op, idx, nw);
      if (ex) begin
        check(!ifEnable[idx] && ifAbort[idx], "R3 abort raised", {ifEnable[idx], ifAbort[idx]}, 2'b01);
        check((ifEnable & ~sel) == (enBefore & ~sel), "R3 others unchanged", ifEnable, enBefore & ~sel);
      end else begin
        check(ifEnable == enBefore, "R7 enable on active ignored", ifEnable, enBefore);
      end
      repeat (dly) @(negedge clk);
      if (dly > 0)
        check(clrCnt[idx] == c0 && doneCnt[idx] == d0 && !ifEnable[idx],
              "R4 wait for drain", clrCnt[idx] - c0, 0);
      drained = '1;
      repeat (8) @(negedge clk);
      for (int i = 0; i < N; i++) tot1 += clrCnt[i];
      check(doneCnt[idx] - d0 == int'(ex), "R2 done count", doneCnt[idx] - d0, ex);
      check(tot1 - tot0 == int'(ex) && clrCnt[idx] - c0 == int'(ex), "R5 single clear", tot1 - tot0, ex);
      if (ex) begin
        check(lastNew[idx] == nw, "R5 config select", lastNew[idx], nw);
        check(archReg[idx] == (nw ? 8'hA0 + 8'(idx) : 8'h10 + 8'(idx)), "R5 reload value",
              archReg[idx], nw ? 8'hA0 + 8'(idx) : 8'h10 + 8'(idx));
        check(ifEnable == '1, "R2 back in service", ifEnable, 8'hFF);
      end
    end

    // R6 merge
    begin
      automatic int c0 = clrCnt[1], d0 = doneCnt[1];
      drained[1] = 1'b0;
      req(1'b0, 1, 1'b0);
      req(1'b0, 1, 1'b1);
      repeat (3) @(negedge clk);
      drained = '1;
      repeat (8) @(negedge clk);
      check(clrCnt[1] - c0 == 1 && doneCnt[1] - d0 == 1, "R6 merged once", doneCnt[1] - d0, 1);
      check(lastNew[1] == 1'b1, "R6 new flag ORed", lastNew[1], 1);
    end

    // R5 ordering: release two at once
    begin
      automatic int n0 = doneN;
      drained[4] = 1'b0; drained[6] = 1'b0;
      req(1'b0, 6, 1'b0);
      req(1'b0, 4, 1'b0);
      @(negedge clk);
      drained = '1;
      repeat (8) @(negedge clk);
      check(doneN - n0 == 2, "R5 two completions", doneN - n0, 2);
      check(doneHist[n0] == 4 && doneHist[n0 + 1] == 6, "R5 lowest index first",
            doneHist[n0], 4);
    end

    // R8 function level reset with a parked reset and a same-cycle request
    begin
      automatic int c2 = clrCnt[2], d2 = doneCnt[2], d7 = doneCnt[7];
      advCount = 4'd6;
      drained[2] = 1'b0;
      req(1'b0, 2, 1'b0);
      @(negedge clk);
      flrReq = 1'b1;
      req(1'b0, 7, 1'b0);
      flrReq = 1'b0;
      check(ifEnable == 8'hC0 && ifAbort == 8'h3F, "R8 sweep below count",
            {ifEnable, ifAbort}, {8'hC0, 8'h3F});
      drained = '1;
      repeat (8) @(negedge clk);
      check(clrCnt[2] == c2 && doneCnt[2] == d2, "R8 pending reset cancelled", doneCnt[2] - d2, 0);
      check(doneCnt[7] == d7 && ifEnable[7], "R8 same-cycle request ignored", doneCnt[7] - d7, 0);
    end

    // R7 reset on an off interface
    begin
      automatic int d0 = doneCnt[0];
      req(1'b0, 0, 1'b0);
      repeat (8) @(negedge clk);
      check(!ifEnable[0] && doneCnt[0] == d0, "R7 reset on off ignored", doneCnt[0] - d0, 0);
    end

    // R8 re-enable after sweep
    for (int i = 0; i < 6; i++) begin
      req(1'b1, i, 1'b1);
      repeat (6) @(negedge clk);
    end
    check(ifEnable == '1, "R8 re-enabled", ifEnable, 8'hFF);
    check(archReg[3] == 8'hA3, "R8 reload new cfg", archReg[3], 8'hA3);
    check(badDone == 0, "R2 done with enable", badDone, 0);

    summary();
  end
endmodule